// File: doc/BRIEF.md
# Paged Framebuffer Refresh Streamer

This block refreshes a page-organised monochrome LCD controller from a one-bit-per-pixel framebuffer. The panel is split into horizontal pages of eight rows. Each page is held as one byte per column, and each byte carries a vertical strip of eight pixels. A single start pulse begins a frame. The streamer then walks the pages from page 0 upward. For each page it asserts chip-select and, in command mode, sends three commands: column high nibble zero (0x10), column low nibble zero (0x00) and page select (0xB0 OR page). It then moves register-select to data mode and sends every column byte of that page, column 0 first. After the page it releases chip-select.

Framebuffer bytes are fetched through a synchronous read port with one cycle of latency. Each byte goes to a serial transmitter through a valid/ready handshake. The transmitter also reports when its shifter is empty. Register-select and chip-select are changed only while the transmitter is empty, so a byte being shifted out never sees its mode flip underneath it.

A double-height mode serves renderers that build 16-row bands. Band n goes out as two consecutive hardware pages, 2n and 2n+1. Each of these pages has its own address commands and its own chip-select window. A band-done pulse tells the renderer when the band it supplied has been consumed.

Top module: `lps_frame_streamer`

## Requirements
- R1: After reset, and whenever no frame is in progress, o_busy, o_tx_valid, o_tx_cs, o_tx_rs, o_rd_en, o_frame_done and o_band_done are all low.
- R2: A one-cycle pulse on i_start while idle starts a frame at page 0, with the pages following in ascending order. A start pulse during a frame has no effect on the byte stream or on the frame count.
- R3: Each page opens with chip-select high (1 = selected) and register-select low (0 = command). Its first two bytes are 0x10 and then 0x00. No byte is offered while chip-select is low.
- R4: The third command byte of page p is 0xB0 OR p.
- R5: After the page command, register-select is 1 (data). The COLS framebuffer bytes at read address p*COLS + c then follow, for c ascending from 0. Each byte is the data returned one cycle after the read request, and no other bytes are sent.
- R6: o_tx_rs changes only at a clock edge where i_tx_idle is high.
- R7: Chip-select falls once per page, after that page's last data byte and at an edge where i_tx_idle is high. It stays low for at least one cycle before the next page.
- R8: While o_tx_valid is high and i_tx_ready is low, o_tx_valid, o_tx_byte and o_tx_rs hold their values.
- R9: o_frame_done is a single-cycle pulse, given exactly once per frame after the last page's chip-select release.
- R10: o_band_done pulses after each page in single mode, and after each odd-numbered page in double-height mode. The mode is taken from i_dbl at the start pulse, and later changes to i_dbl do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | Clock |
| i_rst_n | input | 1 | Asynchronous active-low reset |
| i_start | input | 1 | Frame start pulse |
| i_dbl | input | 1 | Double-height mode select, sampled at start |
| o_busy | output | 1 | Frame in progress |
| o_frame_done | output | 1 | End-of-frame pulse |
| o_band_done | output | 1 | Band consumed pulse |
| o_rd_en | output | 1 | Framebuffer read request |
| o_rd_addr | output | AW | Framebuffer read address, page*COLS + column |
| i_rd_data | input | 8 | Framebuffer read data, one cycle after request |
| o_tx_valid | output | 1 | Byte offered to transmitter |
| i_tx_ready | input | 1 | Transmitter accepts the offered byte |
| i_tx_idle | input | 1 | Transmitter shifter empty |
| o_tx_byte | output | 8 | Byte to transmit |
| o_tx_rs | output | 1 | Register-select: 0 command, 1 data |
| o_tx_cs | output | 1 | Chip-select, 1 = selected |

## Verification
The bench builds the streamer with COLS=16 and PAGES=4, a 64-byte framebuffer. At this size, full frames in both modes, back-to-back frames, page wrap and the last-column and last-page boundaries all occur many times within a short run. Because COLS stays a power of two, the concatenated address variant is used. The four pages still exercise the band pairing of pages 0/1 and 2/3, and a page field value of more than one bit in the page command.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CMD,
    ST_SWITCH,
    ST_RD,
    ST_CAP,
    ST_SEND,
    ST_RELEASE
  } lps_state_e;

  localparam logic [7:0] CMD_COL_HI    = 8'h10;
  localparam logic [7:0] CMD_COL_LO    = 8'h00;
  localparam logic [7:0] CMD_PAGE_BASE = 8'hB0;
  localparam int         NUM_CMDS      = 3;

endpackage

// File: rtl/lps_cursor.sv
module lps_cursor #(
  parameter int COLS  = 128,
  parameter int PAGES = 8,
  localparam int CW   = (COLS  > 1) ? $clog2(COLS)  : 1,
  localparam int PW   = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int AW   = $clog2(COLS * PAGES)
) (
  input  logic          i_clk,
  input  logic          i_rst_n,
  input  logic          i_clr,
  input  logic          i_dbl,
  input  logic          i_col_step,
  input  logic          i_page_step,
  output logic [PW-1:0] o_page,
  output logic [AW-1:0] o_addr,
  output logic          o_last_col,
  output logic          o_last_page,
  output logic          o_band_end
);

  logic [CW-1:0] col_q,  col_d;
  logic [PW-1:0] page_q, page_d;
  logic          dbl_q,  dbl_d;

  assign o_last_col  = (col_q  == CW'(COLS - 1));
  assign o_last_page = (page_q == PW'(PAGES - 1));
  assign o_band_end  = !dbl_q || page_q[0];
  assign o_page      = page_q;

  always_comb begin
    col_d  = col_q;
    page_d = page_q;
    dbl_d  = dbl_q;
    if (i_clr) begin
      col_d  = '0;
      page_d = '0;
      dbl_d  = i_dbl;
    end else begin
      if (i_col_step) begin
        col_d = o_last_col ? '0 : col_q + CW'(1);
      end
      if (i_page_step) begin
        page_d = page_q + PW'(1);
      end
    end
  end

  always_ff @(posedge i_clk or negedge i_rst_n) begin
    if (!i_rst_n) begin
      col_q  <= '0;
      page_q <= '0;
      dbl_q  <= 1'b0;
    end else begin
      col_q  <= col_d;
      page_q <= page_d;
      dbl_q  <= dbl_d;
    end
  end

  generate
    if (COLS == (1 << CW) && AW == CW + PW) begin : g_addr_cat
      assign o_addr = {page_q, col_q};
    end else begin : g_addr_mul
      assign o_addr = AW'(page_q) * AW'(COLS) + AW'(col_q);
    end
  endgenerate

endmodule

// File: rtl/lps_cmd_sel.sv
module lps_cmd_sel
  import lps_pkg::*;
#(
  parameter int PAGES = 8,
  localparam int PW   = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic [1:0]    i_idx,
  input  logic [PW-1:0] i_page,
  output logic [7:0]    o_cmd
);

  logic [7:0] page_ext;

  assign page_ext = {{(8 - PW){1'b0}}, i_page};

  always_comb begin
    case (i_idx)
      2'd0:    o_cmd = CMD_COL_HI;
      2'd1:    o_cmd = CMD_COL_LO;
      default: o_cmd = CMD_PAGE_BASE | page_ext;
    endcase
  end

endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
  import lps_pkg::*;
(
  input  logic       i_clk,
  input  logic       i_rst_n,
  input  logic       i_start,
  input  logic       i_tx_ready,
  input  logic       i_tx_idle,
  input  logic [7:0] i_rd_data,
  input  logic [7:0] i_cmd,
  input  logic       i_last_col,
  input  logic       i_last_page,
  input  logic       i_band_end,
  output logic [1:0] o_cmd_idx,
  output logic       o_clr,
  output logic       o_col_step,
  output logic       o_page_step,
  output logic       o_rd_en,
  output logic       o_tx_valid,
  output logic [7:0] o_tx_byte,
  output logic       o_tx_rs,
  output logic       o_tx_cs,
  output logic       o_frame_done,
  output logic       o_band_done,
  output logic       o_busy
);

  lps_state_e state_q, state_d;
  logic [1:0] idx_q,   idx_d;
  logic [7:0] byte_q,  byte_d;
  logic       cs_q,    cs_d;
  logic       rs_q,    rs_d;
  logic       fd_q,    fd_d;
  logic       bd_q,    bd_d;

  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    byte_d      = byte_q;
    cs_d        = cs_q;
    rs_d        = rs_q;
    fd_d        = 1'b0;
    bd_d        = 1'b0;
    o_clr       = 1'b0;
    o_col_step  = 1'b0;
    o_page_step = 1'b0;
    o_rd_en     = 1'b0;
    o_tx_valid  = 1'b0;
    o_tx_byte   = byte_q;
    case (state_q)
      ST_IDLE: begin
        if (i_start) begin
          o_clr   = 1'b1;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        cs_d    = 1'b1;
        idx_d   = '0;
        state_d = ST_CMD;
      end
      ST_CMD: begin
        o_tx_valid = 1'b1;
        o_tx_byte  = i_cmd;
        if (i_tx_ready) begin
          if (idx_q == 2'(NUM_CMDS - 1)) begin
            state_d = ST_SWITCH;
          end else begin
            idx_d = idx_q + 2'd1;
          end
        end
      end
      ST_SWITCH: begin
        if (i_tx_idle) begin
          rs_d    = 1'b1;
          state_d = ST_RD;
        end
      end
      ST_RD: begin
        o_rd_en = 1'b1;
        state_d = ST_CAP;
      end
      ST_CAP: begin
        byte_d  = i_rd_data;
        state_d = ST_SEND;
      end
      ST_SEND: begin
        o_tx_valid = 1'b1;
        if (i_tx_ready) begin
          o_col_step = 1'b1;
          state_d    = i_last_col ? ST_RELEASE : ST_RD;
        end
      end
      ST_RELEASE: begin
        if (i_tx_idle) begin
          cs_d = 1'b0;
          rs_d = 1'b0;
          bd_d = i_band_end;
          if (i_last_page) begin
            fd_d    = 1'b1;
            state_d = ST_IDLE;
          end else begin
            o_page_step = 1'b1;
            state_d     = ST_SETUP;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge i_clk or negedge i_rst_n) begin
    if (!i_rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      byte_q  <= '0;
      cs_q    <= 1'b0;
      rs_q    <= 1'b0;
      fd_q    <= 1'b0;
      bd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      byte_q  <= byte_d;
      cs_q    <= cs_d;
      rs_q    <= rs_d;
      fd_q    <= fd_d;
      bd_q    <= bd_d;
    end
  end

  assign o_cmd_idx    = idx_q;
  assign o_tx_rs      = rs_q;
  assign o_tx_cs      = cs_q;
  assign o_frame_done = fd_q;
  assign o_band_done  = bd_q;
  assign o_busy       = (state_q != ST_IDLE);

endmodule

// File: rtl/lps_frame_streamer.sv
module lps_frame_streamer #(
  parameter int COLS  = 128,
  parameter int PAGES = 8,
  localparam int PW   = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int AW   = $clog2(COLS * PAGES)
) (
  input  logic          i_clk,
  input  logic          i_rst_n,
  input  logic          i_start,
  input  logic          i_dbl,
  output logic          o_busy,
  output logic          o_frame_done,
  output logic          o_band_done,
  output logic          o_rd_en,
  output logic [AW-1:0] o_rd_addr,
  input  logic [7:0]    i_rd_data,
  output logic          o_tx_valid,
  input  logic          i_tx_ready,
  input  logic          i_tx_idle,
  output logic [7:0]    o_tx_byte,
  output logic          o_tx_rs,
  output logic          o_tx_cs
);

  logic [1:0]    rst_sync_q;
  logic          rst_n;
  logic [1:0]    cmd_idx;
  logic [7:0]    cmd_byte;
  logic [PW-1:0] page;
  logic          clr, col_step, page_step;
  logic          last_col, last_page, band_end;

  always_ff @(posedge i_clk or negedge i_rst_n) begin
    if (!i_rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  lps_cursor #(.COLS(COLS), .PAGES(PAGES)) u_cursor (
    .i_clk       (i_clk),
    .i_rst_n     (rst_n),
    .i_clr       (clr),
    .i_dbl       (i_dbl),
    .i_col_step  (col_step),
    .i_page_step (page_step),
    .o_page      (page),
    .o_addr      (o_rd_addr),
    .o_last_col  (last_col),
    .o_last_page (last_page),
    .o_band_end  (band_end)
  );

  lps_cmd_sel #(.PAGES(PAGES)) u_cmd_sel (
    .i_idx  (cmd_idx),
    .i_page (page),
    .o_cmd  (cmd_byte)
  );

  lps_ctrl u_ctrl (
    .i_clk        (i_clk),
    .i_rst_n      (rst_n),
    .i_start      (i_start),
    .i_tx_ready   (i_tx_ready),
    .i_tx_idle    (i_tx_idle),
    .i_rd_data    (i_rd_data),
    .i_cmd        (cmd_byte),
    .i_last_col   (last_col),
    .i_last_page  (last_page),
    .i_band_end   (band_end),
    .o_cmd_idx    (cmd_idx),
    .o_clr        (clr),
    .o_col_step   (col_step),
    .o_page_step  (page_step),
    .o_rd_en      (o_rd_en),
    .o_tx_valid   (o_tx_valid),
    .o_tx_byte    (o_tx_byte),
    .o_tx_rs      (o_tx_rs),
    .o_tx_cs      (o_tx_cs),
    .o_frame_done (o_frame_done),
    .o_band_done  (o_band_done),
    .o_busy       (o_busy)
  );

endmodule

// File: rtl/lps_checker.sv
module lps_checker #(
  parameter int COLS  = 128,
  parameter int PAGES = 8,
  localparam int AW   = $clog2(COLS * PAGES)
) (
  input logic          i_clk,
  input logic          i_rst_n,
  input logic          o_busy,
  input logic          o_frame_done,
  input logic          o_band_done,
  input logic          o_rd_en,
  input logic [AW-1:0] o_rd_addr,
  input logic          o_tx_valid,
  input logic          i_tx_ready,
  input logic          i_tx_idle,
  input logic [7:0]    o_tx_byte,
  input logic          o_tx_rs,
  input logic          o_tx_cs
);

  AST_IDLE_QUIET: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    !o_busy |-> !o_tx_valid && !o_tx_cs && !o_rd_en);                              // R1

  AST_VALID_NEEDS_CS: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    o_tx_valid |-> o_tx_cs);                                                        // R3

  AST_READ_IN_DATA_MODE: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    o_rd_en |-> o_tx_rs && o_tx_cs && ({1'b0, o_rd_addr} < (AW + 1)'(COLS * PAGES))); // R5

  AST_RS_ONLY_WHEN_IDLE: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    !$stable(o_tx_rs) |-> $past(i_tx_idle));                                        // R6

  AST_CS_FALL_WHEN_IDLE: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    $fell(o_tx_cs) |-> $past(i_tx_idle));                                           // R7

  AST_HOLD_UNDER_STALL: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    o_tx_valid && !i_tx_ready |=> o_tx_valid && $stable(o_tx_byte) && $stable(o_tx_rs)); // R8

  AST_DONE_SINGLE: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    o_frame_done |=> !o_frame_done);                                                // R9

  AST_DONE_ENDS_BAND: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    o_frame_done |-> o_band_done && !o_tx_cs);                                      // R10

endmodule

bind lps_frame_streamer lps_checker #(.COLS(COLS), .PAGES(PAGES)) u_lps_checker (
  .i_clk        (i_clk),
  .i_rst_n      (i_rst_n),
  .o_busy       (o_busy),
  .o_frame_done (o_frame_done),
  .o_band_done  (o_band_done),
  .o_rd_en      (o_rd_en),
  .o_rd_addr    (o_rd_addr),
  .o_tx_valid   (o_tx_valid),
  .i_tx_ready   (i_tx_ready),
  .i_tx_idle    (i_tx_idle),
  .o_tx_byte    (o_tx_byte),
  .o_tx_rs      (o_tx_rs),
  .o_tx_cs      (o_tx_cs)
);

// File: tb/test_lps_frame_streamer.sv
module test_lps_frame_streamer;

  localparam int COLS  = 16;
  localparam int PAGES = 4;
  localparam int AW    = $clog2(COLS * PAGES);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          dbl = 1'b0;
  logic          busy, frame_done, band_done, rd_en;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data = 8'h00;
  logic          tx_valid, tx_rs, tx_cs;
  logic          tx_ready = 1'b0;
  logic          tx_idle = 1'b1;
  logic [7:0]    tx_byte;

  always #4 clk = ~clk;

  lps_frame_streamer #(.COLS(COLS), .PAGES(PAGES)) i_lps_frame_streamer (
    .i_clk        (clk),
    .i_rst_n      (rst_n),
    .i_start      (start),
    .i_dbl        (dbl),
    .o_busy       (busy),
    .o_frame_done (frame_done),
    .o_band_done  (band_done),
    .o_rd_en      (rd_en),
    .o_rd_addr    (rd_addr),
    .i_rd_data    (rd_data),
    .o_tx_valid   (tx_valid),
    .i_tx_ready   (tx_ready),
    .i_tx_idle    (tx_idle),
    .o_tx_byte    (tx_byte),
    .o_tx_rs      (tx_rs),
    .o_tx_cs      (tx_cs)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int cur_seed = 0;
  bit cur_dbl = 1'b0;
  bit no_stall = 1'b0;

  function automatic logic [7:0] fb_val(input int addr, input int seed);
    return 8'((addr * 37 + seed * 11) ^ (addr >> 2) ^ 8'h5A);
  endfunction

  // framebuffer model: synchronous read, one cycle latency
  always @(posedge clk) begin
    if (rd_en) rd_data <= fb_val(int'(rd_addr), cur_seed);
  end

  logic [8:0] q_exp[$];
  int frame_cnt = 0;
  int band_cnt = 0;
  int cs_falls = 0;

  // transmitter model and monitor
  logic [15:0] lfsr = 16'hACE1;
  int   busy_cnt = 0;
  bit   pend = 1'b0;
  bit   prev_v = 1'b0;
  logic [8:0] prev_item = '0;
  bit   prev_idle = 1'b1;
  bit   prev_rs = 1'b0, prev_cs = 1'b0, prev_fd = 1'b0;

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!rst_n) begin
      tx_idle = 1'b1; tx_ready = 1'b0; pend = 1'b0; busy_cnt = 0;
      prev_v = 1'b0; prev_rs = 1'b0; prev_cs = 1'b0; prev_fd = 1'b0; prev_idle = 1'b1;
    end else begin
      if (tx_rs !== prev_rs) chk(prev_idle, "R6 rs changed while transmitter busy", int'(prev_idle), 1);
      if (prev_cs && !tx_cs) begin
        chk(prev_idle, "R7 cs released while transmitter busy", int'(prev_idle), 1);
        cs_falls++;
      end
      if (band_done) begin
        band_cnt++;
        if (cur_dbl) chk(cs_falls % 2 == 0, "R10 band pulse after even page in double mode", cs_falls, 0);
      end
      if (frame_done) begin
        frame_cnt++;
        chk(!prev_fd, "R9 frame_done wider than one cycle", int'(prev_fd), 0);
      end
      if (prev_v && !pend)
        chk(tx_valid && ({tx_rs, tx_byte} == prev_item), "R8 offer changed under stall",
            int'({tx_valid, tx_rs, tx_byte}), int'({1'b1, prev_item}));
      if (pend) begin
        pend = 1'b0;
        busy_cnt = 1 + int'(lfsr[1:0]);
        tx_idle = 1'b0;
        tx_ready = 1'b0;
      end else begin
        if (busy_cnt > 0) busy_cnt--;
        tx_idle = (busy_cnt == 0);
        tx_ready = tx_idle && (no_stall || lfsr[4] || lfsr[7]);
        if (tx_valid && tx_ready) begin
          chk(tx_cs, "R3 byte offered with chip-select low", int'(tx_cs), 1);
          if (q_exp.size() == 0) begin
            chk(1'b0, "R5 unexpected byte", int'({tx_rs, tx_byte}), 0);
          end else begin
            logic [8:0] e;
            string tag;
            e = q_exp.pop_front();
            tag = e[8] ? "R5 data byte" : ((e[7:4] == 4'hB) ? "R4 page command" : "R3 column command");
            chk({tx_rs, tx_byte} == e, tag, int'({tx_rs, tx_byte}), int'(e));
          end
          pend = 1'b1;
        end
      end
      prev_idle = tx_idle;
      prev_v = tx_valid;
      prev_item = {tx_rs, tx_byte};
      prev_rs = tx_rs;
      prev_cs = tx_cs;
      prev_fd = frame_done;
    end
  end

  // driver: push expected stream, then run one frame
  task automatic run_frame(input bit md, input int seed, input bit retrig, input bit flip);
    cur_seed = seed;
    cur_dbl = md;
    frame_cnt = 0; band_cnt = 0; cs_falls = 0;
    for (int p = 0; p < PAGES; p++) begin
      q_exp.push_back({1'b0, 8'h10});
      q_exp.push_back({1'b0, 8'h00});
      q_exp.push_back({1'b0, 8'hB0 | 8'(p)});
      for (int c = 0; c < COLS; c++) q_exp.push_back({1'b1, fb_val(p * COLS + c, seed)});
    end
    @(negedge clk);
    dbl = md; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (flip) dbl = !md;
    if (retrig) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int t = 0; t < 20000 && frame_cnt == 0; t++) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(frame_cnt == 1, "R9 one frame_done per frame", frame_cnt, 1);
    chk(q_exp.size() == 0, "R5 all expected bytes sent", q_exp.size(), 0);
    chk(cs_falls == PAGES, "R7 one chip-select release per page", cs_falls, PAGES);
    chk(band_cnt == (md ? PAGES / 2 : PAGES), "R10 band pulse count", band_cnt, md ? PAGES / 2 : PAGES);
    chk(!busy && !tx_cs && !tx_rs, "R1 idle after frame", int'({busy, tx_cs, tx_rs}), 0);
    if (retrig) chk(frame_cnt == 1 && q_exp.size() == 0, "R2 start during frame ignored", frame_cnt, 1);
    q_exp.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !tx_valid && !tx_cs && !tx_rs && !rd_en && !frame_done && !band_done,
        "R1 outputs during reset", int'({busy, tx_valid, tx_cs, tx_rs, rd_en, frame_done, band_done}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && !tx_valid && !tx_cs && !rd_en, "R1 outputs after reset",
        int'({busy, tx_valid, tx_cs, rd_en}), 0);
    run_frame(1'b0, 1, 1'b0, 1'b0);  // R2 R5 single mode with stalls
    run_frame(1'b1, 2, 1'b0, 1'b0);  // R10 double mode
    run_frame(1'b0, 3, 1'b1, 1'b0);  // R2 retrigger ignored
    no_stall = 1'b1;
    run_frame(1'b1, 4, 1'b0, 1'b1);  // R10 mode latched at start
    run_frame(1'b0, 5, 1'b0, 1'b1);  // R10 single latched, dbl raised mid-frame
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule